// File: doc/BRIEF.md
# Daisy-Chain Vectored Interrupt Controller with Nested Priority Groups

This block gathers the interrupt request lines of eight devices and presents one combined request to the processor. When the processor acknowledges, the acknowledge travels along a fixed chain. The chain starts at device 0 and ends at device 7. The first eligible requesting device takes the acknowledge and stops it from travelling further. In the same cycle the block returns that device's vector code, which the processor uses to pick the service routine.

The devices form two priority groups. Devices 0 to 3 are group 0, which has the higher priority. Devices 4 to 7 are group 1. A two-entry stack records the group of every service in progress. While the processor's interrupt-enable bit is clear, only a request from a group strictly higher than the one on top of the stack is accepted, so such a request can nest over the current service. An end-of-service strobe pops the stack and returns to the previous level.

Top module: `dcvi_top`

## Requirements
- R1: `irq` is the OR of all eight bits of `dev_req` in the same cycle. The enable bit and the stack do not affect it.
- R2: `dev_ack` is zero unless `cpu_ack` is high in that cycle. At most one bit of `dev_ack` is set, and it lasts only for the cycle in which `cpu_ack` is high.
- R3: During an acknowledge, the device granted is the lowest-numbered device that is eligible and requesting. Every device before it in the chain passes the acknowledge on. A device with no request never receives it.
- R4: `vector` equals 4 × the granted device index (8 bits) in the cycle of `dev_ack`, and is 0 in every other cycle.
- R5: With `cpu_ie` = 1 and the stack not full, every requesting device is eligible.
- R6: With `cpu_ie` = 0, a device is eligible only if the stack is non-empty and its group number (index / 4) is strictly less than the group on top of the stack. With an empty stack, no device is eligible.
- R7: Each grant pushes the granted device's group onto a stack of depth 2. While the stack is full, no device is eligible.
- R8: `eos` pops one entry and restores the previous group level. `eos` on an empty stack is ignored. When `eos` and a grant fall in the same cycle, eligibility uses the stack as it was before that cycle, and the pop takes effect before the push.
- R9: After reset the stack is empty. An acknowledge with `cpu_ie` = 0 therefore grants no device.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dev_req | input | 8 | Per-device request lines; bit i is device i |
| cpu_ack | input | 1 | Processor acknowledge, one-cycle pulse |
| cpu_ie | input | 1 | Processor interrupt-enable bit |
| eos | input | 1 | End-of-service strobe |
| irq | output | 1 | Combined request to the processor |
| dev_ack | output | 8 | Per-device acknowledge; at most one bit set |
| vector | output | 8 | Vector code of the granted device |

## Verification
The bench first applies directed patterns:
- Several simultaneous requests spread across both groups, which shows whether the lowest eligible index wins.
- A request from the same group as the active service, and then one from the higher group, with the enable bit clear. This separates a correct strict-priority comparison from one that uses less-or-equal or ignores the stack.
- Acknowledges with a full stack and with an empty stack, together with pops on an empty stack and a pop that coincides with a grant. These expose off-by-one faults in the stack count.

After the directed patterns, long runs of random requests, acknowledges, enable values and strobes are compared every cycle against a behavioural queue model. These runs reach interleavings that the directed patterns miss.

// File: rtl/dcvi_pkg.sv
package dcvi_pkg;
    localparam int DCVI_NUM_DEV    = 8;
    localparam int DCVI_NUM_GRP    = 2;
    localparam int DCVI_VEC_W      = 8;
    localparam int DCVI_VEC_STRIDE = 4;
    localparam int DCVI_STK_DEPTH  = 2;
endpackage

// File: rtl/dcvi_chain.sv
module dcvi_chain #(
    parameter int N = 8
) (
    input  logic [N-1:0] req_elig,
    input  logic         ack_in,
    output logic [N-1:0] ack_out
);
    logic [N:0] pass;

    assign pass[0] = ack_in;

    generate
        for (genvar i = 0; i < N; i++) begin : g_link
            // a requesting link keeps the acknowledge, an idle link forwards it
            assign ack_out[i]  = pass[i] & req_elig[i];
            assign pass[i + 1] = pass[i] & ~req_elig[i];
        end
    endgenerate
endmodule

// File: rtl/dcvi_grp_stack.sv
module dcvi_grp_stack #(
    parameter int DEPTH = 2,
    parameter int GRP_W = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [GRP_W-1:0] push_grp,
    input  logic             pop,
    output logic             empty,
    output logic             full,
    output logic [GRP_W-1:0] top_grp
);
    localparam int CNT_W = $clog2(DEPTH + 1);

    typedef struct packed {
        logic [CNT_W-1:0]            cnt;
        logic [DEPTH-1:0][GRP_W-1:0] lvl;
    } stk_t;

    stk_t st_d, st_q;
    logic [CNT_W-1:0] base;

    always_comb begin
        st_d = st_q;
        base = st_q.cnt;
        if (pop && st_q.cnt != '0) begin
            base = st_q.cnt - CNT_W'(1);
        end
        st_d.cnt = base;
        if (push) begin
            for (int k = 0; k < DEPTH; k++) begin
                if (CNT_W'(k) == base) begin
                    st_d.lvl[k] = push_grp;
                end
            end
            st_d.cnt = base + CNT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        top_grp = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (CNT_W'(k + 1) == st_q.cnt) begin
                top_grp = st_q.lvl[k];
            end
        end
    end

    assign empty = (st_q.cnt == '0);
    assign full  = (st_q.cnt == CNT_W'(DEPTH));

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full); // R7
    AST_POP_RESTORES: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && !empty) |=> (st_q.cnt == $past(st_q.cnt) - CNT_W'(1))); // R8
    AST_EMPTY_POP_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && !push && empty) |=> empty); // R8
endmodule

// File: rtl/dcvi_top.sv
module dcvi_top
    import dcvi_pkg::*;
#(
    parameter int NUM_DEV    = DCVI_NUM_DEV,
    parameter int NUM_GRP    = DCVI_NUM_GRP,
    parameter int VEC_W      = DCVI_VEC_W,
    parameter int VEC_STRIDE = DCVI_VEC_STRIDE,
    parameter int STK_DEPTH  = DCVI_STK_DEPTH
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DEV-1:0] dev_req,
    input  logic               cpu_ack,
    input  logic               cpu_ie,
    input  logic               eos,
    output logic               irq,
    output logic [NUM_DEV-1:0] dev_ack,
    output logic [VEC_W-1:0]   vector
);
    localparam int DEV_PER_GRP = NUM_DEV / NUM_GRP;
    localparam int GRP_W       = (NUM_GRP > 1) ? $clog2(NUM_GRP) : 1;

    logic               stk_empty, stk_full;
    logic [GRP_W-1:0]   top_grp;
    logic [NUM_GRP-1:0] grp_ok;
    logic [NUM_DEV-1:0] req_elig;
    logic               grant;
    logic [GRP_W-1:0]   grant_grp;

    assign irq = |dev_req;

    generate
        for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
            // strictly higher group (lower number) may nest while disabled
            assign grp_ok[g] = !stk_full &&
                (cpu_ie || (!stk_empty && (GRP_W'(g) < top_grp)));
        end
        for (genvar i = 0; i < NUM_DEV; i++) begin : g_dev
            assign req_elig[i] = dev_req[i] & grp_ok[i / DEV_PER_GRP];
        end
    endgenerate

    dcvi_chain #(.N(NUM_DEV)) u_chain (
        .req_elig (req_elig),
        .ack_in   (cpu_ack),
        .ack_out  (dev_ack)
    );

    assign grant = |dev_ack;

    always_comb begin
        vector    = '0;
        grant_grp = '0;
        for (int i = 0; i < NUM_DEV; i++) begin
            if (dev_ack[i]) begin
                vector    = VEC_W'(i * VEC_STRIDE);
                grant_grp = GRP_W'(i / DEV_PER_GRP);
            end
        end
    end

    dcvi_grp_stack #(.DEPTH(STK_DEPTH), .GRP_W(GRP_W)) u_stack (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (grant),
        .push_grp (grant_grp),
        .pop      (eos),
        .empty    (stk_empty),
        .full     (stk_full),
        .top_grp  (top_grp)
    );

    AST_ACK_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(dev_ack)); // R2
    AST_ACK_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack != '0) |-> cpu_ack); // R2
    AST_ACK_HAS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        ((dev_ack & ~dev_req) == '0)); // R3
    AST_VEC_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (dev_ack == '0) |-> (vector == '0)); // R4
    AST_MASKED_NEST: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !cpu_ie) |-> !stk_empty); // R6
    AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        stk_full |-> (dev_ack == '0)); // R7
endmodule

// File: tb/tb_dcvi_top.sv
module tb_dcvi_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] dev_req = '0;
    logic       cpu_ack = 1'b0;
    logic       cpu_ie = 1'b0;
    logic       eos = 1'b0;
    logic       irq;
    logic [7:0] dev_ack;
    logic [7:0] vector;

    int checks = 0;
    int errors = 0;
    int stk[$];

    always #10 clk = ~clk;

    dcvi_top dut (
        .clk(clk), .rst_n(rst_n), .dev_req(dev_req), .cpu_ack(cpu_ack),
        .cpu_ie(cpu_ie), .eos(eos), .irq(irq), .dev_ack(dev_ack), .vector(vector)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // one cycle: drive, compare against model, advance model at the edge
    task automatic step(input logic [7:0] r, input logic a, input logic ie,
                        input logic e, input string tag);
        int win;
        logic [7:0] exp_ack;
        @(negedge clk);
        dev_req = r; cpu_ack = a; cpu_ie = ie; eos = e;
        #2;
        win = -1;
        if (a && stk.size() < 2) begin
            for (int i = 0; i < 8; i++) begin
                if (win < 0 && r[i]) begin
                    if (ie || (stk.size() > 0 && (i / 4) < stk[$])) win = i;
                end
            end
        end
        exp_ack = (win >= 0) ? (8'd1 << win) : 8'd0;
        chk("R1 irq", int'(irq), int'(|r));
        chk({tag, " dev_ack"}, int'(dev_ack), int'(exp_ack));
        chk("R4 vector", int'(vector), (win >= 0) ? win * 4 : 0);
        chk("R2 onehot", int'($countones(dev_ack) <= 1), 1);
        @(posedge clk);
        if (e && stk.size() > 0) void'(stk.pop_back());
        if (win >= 0) stk.push_back(win / 4);
    endtask

    initial begin
        #2_000_000;
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R9: empty after reset, disabled acknowledge grants nothing
        step(8'h11, 1, 0, 0, "R9");
        // R3: lowest eligible index wins across groups
        step(8'b0110_0100, 1, 1, 0, "R3");
        step(8'h00, 0, 0, 1, "R8");
        // R5: enabled, group-1 device accepted
        step(8'h80, 1, 1, 0, "R5");
        // R6: same group cannot nest, higher group can
        step(8'ha0, 1, 0, 0, "R6");
        step(8'h88, 1, 0, 0, "R6");
        // R7: stack full blocks even enabled requests
        step(8'h01, 1, 1, 0, "R7");
        step(8'h00, 0, 0, 1, "R8");
        // R8: after pop, group 1 level restored: group 0 nests again
        step(8'h22, 1, 0, 0, "R8");
        step(8'h00, 0, 0, 1, "R8");
        step(8'h00, 0, 0, 1, "R8");
        // R6: empty stack, disabled: nothing
        step(8'h01, 1, 0, 0, "R6");
        // R8: pop on empty ignored
        step(8'h00, 0, 0, 1, "R8");
        step(8'h10, 1, 0, 0, "R8");
        step(8'h10, 1, 1, 0, "R5");
        // R8: pop and grant together
        step(8'h40, 1, 1, 1, "R8");
        step(8'h04, 1, 0, 0, "R8");
        step(8'h00, 0, 0, 1, "R8");
        step(8'h00, 0, 0, 1, "R8");
        // R3: random traffic compared each cycle
        for (int n = 0; n < 3000; n++) begin
            step(8'($urandom), ($urandom % 3) != 0, ($urandom % 3) == 0,
                 ($urandom % 4) == 0, "R3");
        end
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule